// File: doc/BRIEF.md
# One-Wire Temperature Sensor Reader

This block is a complete bus master for a single digital temperature sensor on a one-wire bus. One request runs a fixed transaction. The master resets the bus and checks that a device answers. It then addresses the only device on the bus, starts a temperature conversion and waits for the conversion to finish. Next it addresses the device again, asks for its scratchpad and shifts in the temperature bits. No bus controller sits outside the block: each reset pulse, write slot and read slot is timed inside it from a microsecond base. That base comes from a parameterised clock divider, 50 clocks per microsecond by default.

The bus is open-drain. The block brings out a drive-low enable and takes back the sampled line level. The pad outside pulls the wire low while the enable is set and releases it to high impedance otherwise. When the reading completes, the temperature word is updated and a one-clock ready strobe is raised. If no device answers the reset, an error flag is set and nothing further is driven onto the bus.

Top module: `owtemp_reader`

## Requirements
- R1: While reset is asserted, and after it until a request arrives, the drive-low enable, the ready strobe and the error flag are all 0, and the temperature output is 0.
- R2: A request accepted in the idle state drives the line low for 480 us, starting on the next clock. The first command slot starts exactly 960 us after the start of that reset pulse.
- R3: The line is sampled 70 us after the reset pulse is released, and a low level counts as a presence response. Without a response, the error flag is set at the end of the 960 us window and no further low pulse is driven. A later accepted request clears the flag on the clock that accepts it.
- R4: Four command bytes are sent in this order: 0xCC, 0x44, 0xCC, 0xBE. Each byte goes least significant bit first. A 1 bit is a 6 us low pulse and a 0 bit is a 60 us low pulse.
- R5: Every write or read slot lasts 65 us, followed by a 1 us recovery gap. Within one phase, consecutive slots therefore start exactly 66 us apart.
- R6: After the second command byte, the bus stays released for a 750 ms conversion wait. The third command byte's first slot starts exactly 66 us plus 750 ms after the start of the last slot of the second byte.
- R7: Each read slot drives the line low for 6 us and samples it 15 us after the slot starts. Twelve slots are read. The first bit read lands in bit 0 of the temperature output and the last in bit 11.
- R8: The ready strobe is high for exactly one clock, 66 us after the start of the final read slot. The new temperature value is on the output in that same clock.
- R9: A request that arrives while a transaction is running has no effect on the bus timing. No new transaction starts until the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Starts a transaction when sampled high while idle |
| bus_in_i | input | 1 | Sampled level of the one-wire line |
| bus_drive_low_o | output | 1 | When high, the pad pulls the line low; otherwise it is released |
| temp_o | output | DATA_BITS | Raw temperature word, least significant bit read first |
| ready_o | output | 1 | One-clock strobe when a new temperature word is valid |
| error_o | output | 1 | Set when no presence response was seen |

## Verification
Every result is due a fixed number of clocks after the edge that caused it, so the bench predicts each one as a count. The reset pulse begins one clock after the request is accepted. Each later low pulse starts a known number of microsecond multiples after the previous pulse started: 960, 66, or 66 plus the conversion wait. The ready strobe rises 66 microseconds after the last read slot started, and the error flag follows the start of the reset pulse by one full window. The monitor timestamps every rising and falling edge of the drive enable, and every ready strobe, against one free-running cycle counter sampled on the falling clock edge. It compares these timestamps, as exact differences, with the widths and periods the driver queued.

// File: rtl/owtemp_pkg.sv
package owtemp_pkg;

   typedef enum logic [1:0] {
      SLOT_RESET,
      SLOT_WR0,
      SLOT_WR1,
      SLOT_READ
   } slot_kind_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_RESET,
      SQ_WRITE,
      SQ_CONVERT,
      SQ_READ
   } seq_state_e;

   localparam int NUM_CMD_BYTES = 4;

   // command bytes in transmit order: address-all, convert, address-all, read scratchpad
   function automatic logic [7:0] cmd_byte(input logic [1:0] idx);
      case (idx)
         2'd0, 2'd2: return 8'hCC;
         2'd1:       return 8'h44;
         default:    return 8'hBE;
      endcase
   endfunction

endpackage

// File: rtl/owtemp_slot.sv
module owtemp_slot
   import owtemp_pkg::*;
#(
   parameter int CLKS_PER_US    = 50,
   parameter int RESET_LOW_US   = 480,
   parameter int RESET_WIN_US   = 960,
   parameter int PRES_SAMPLE_US = 70,
   parameter int SLOT_US        = 65,
   parameter int RECOVERY_US    = 1,
   parameter int WR1_LOW_US     = 6,
   parameter int WR0_LOW_US     = 60,
   parameter int RD_LOW_US      = 6,
   parameter int RD_SAMPLE_US   = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  slot_kind_e kind_i,
   input  logic       line_i,
   output logic       done_o,
   output logic       drive_low_o,
   output logic       sample_o
);

   localparam int RST_LOW_C  = RESET_LOW_US * CLKS_PER_US;
   localparam int RST_WIN_C  = RESET_WIN_US * CLKS_PER_US;
   localparam int RST_SAMP_C = (RESET_LOW_US + PRES_SAMPLE_US) * CLKS_PER_US;
   localparam int SLOT_TOT_C = (SLOT_US + RECOVERY_US) * CLKS_PER_US;
   localparam int WR1_C      = WR1_LOW_US * CLKS_PER_US;
   localparam int WR0_C      = WR0_LOW_US * CLKS_PER_US;
   localparam int RD_LOW_C   = RD_LOW_US * CLKS_PER_US;
   localparam int RD_SAMP_C  = RD_SAMPLE_US * CLKS_PER_US;
   localparam int CNT_W      = $clog2(RST_WIN_C + 1);

   generate
      if (CLKS_PER_US < 1) begin : g_bad_div
         $error("CLKS_PER_US must be at least 1");
      end
      if (RESET_LOW_US + PRES_SAMPLE_US >= RESET_WIN_US) begin : g_bad_pres
         $error("presence sample point must lie inside the reset window");
      end
      if (RESET_WIN_US <= SLOT_US + RECOVERY_US) begin : g_bad_win
         $error("reset window must be longer than a bit slot");
      end
      if (WR1_LOW_US >= WR0_LOW_US || WR0_LOW_US >= SLOT_US) begin : g_bad_wr
         $error("write pulse widths must be ordered and fit inside the slot");
      end
      if (RD_LOW_US >= RD_SAMPLE_US || RD_SAMPLE_US >= SLOT_US) begin : g_bad_rd
         $error("read sample point must follow the read pulse and fit the slot");
      end
      if (RECOVERY_US < 1) begin : g_bad_rec
         $error("a recovery gap of at least 1 us is needed");
      end
   endgenerate

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   slot_kind_e       kind_q;
   logic             samp_q;
   logic [CNT_W-1:0] low_len;
   logic [CNT_W-1:0] total_len;
   logic [CNT_W-1:0] samp_at;
   logic             samp_en;
   logic             last;

   always_comb begin
      samp_at = CNT_W'(RD_SAMP_C);
      samp_en = 1'b0;
      case (kind_q)
         SLOT_RESET: begin
            low_len   = CNT_W'(RST_LOW_C);
            total_len = CNT_W'(RST_WIN_C);
            samp_at   = CNT_W'(RST_SAMP_C);
            samp_en   = 1'b1;
         end
         SLOT_WR0: begin
            low_len   = CNT_W'(WR0_C);
            total_len = CNT_W'(SLOT_TOT_C);
         end
         SLOT_WR1: begin
            low_len   = CNT_W'(WR1_C);
            total_len = CNT_W'(SLOT_TOT_C);
         end
         default: begin
            low_len   = CNT_W'(RD_LOW_C);
            total_len = CNT_W'(SLOT_TOT_C);
            samp_en   = 1'b1;
         end
      endcase
   end

   assign last        = busy_q && (cnt_q == total_len - 1'b1);
   assign done_o      = last;
   assign drive_low_o = busy_q && (cnt_q < low_len);
   assign sample_o    = samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         kind_q <= SLOT_RESET;
      end else if (start_i && (!busy_q || last)) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         kind_q <= kind_i;
      end else if (last) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= 1'b1;
      end else if (busy_q && samp_en && cnt_q == samp_at) begin
         samp_q <= line_i;
      end
   end

   // R5
   slot_start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (!busy_q || last));

   // R2
   slot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_low_o) |-> busy_q || $past(last));

endmodule

// File: rtl/owtemp_usdelay.sv
module owtemp_usdelay #(
   parameter int CLKS_PER_US = 50,
   parameter int DELAY_US    = 750000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic done_o
);

   localparam int US_W = (DELAY_US > 1) ? $clog2(DELAY_US) : 1;

   generate
      if (DELAY_US < 1) begin : g_bad_delay
         $error("DELAY_US must be at least 1");
      end
   endgenerate

   logic            busy_q;
   logic [US_W-1:0] us_q;
   logic            tick;

   generate
      if (CLKS_PER_US == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_prescale
         localparam int PRE_W = $clog2(CLKS_PER_US);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (start_i || !busy_q || tick) begin
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end
         assign tick = (pre_q == PRE_W'(CLKS_PER_US - 1));
      end
   endgenerate

   assign done_o = busy_q && tick && (us_q == US_W'(DELAY_US - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         us_q   <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         us_q   <= '0;
      end else if (done_o) begin
         busy_q <= 1'b0;
         us_q   <= '0;
      end else if (busy_q && tick) begin
         us_q <= us_q + 1'b1;
      end
   end

   // R6
   dly_done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_q || $past(start_i));

endmodule

// File: rtl/owtemp_seq.sv
module owtemp_seq
   import owtemp_pkg::*;
#(
   parameter int DATA_BITS = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic                 slot_done_i,
   input  logic                 slot_sample_i,
   input  logic                 dly_done_i,
   output logic                 slot_start_o,
   output slot_kind_e           slot_kind_o,
   output logic                 dly_start_o,
   output logic [DATA_BITS-1:0] temp_o,
   output logic                 ready_o,
   output logic                 error_o
);

   localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

   generate
      if (DATA_BITS < 2) begin : g_bad_bits
         $error("DATA_BITS must be at least 2");
      end
   endgenerate

   seq_state_e           state_q;
   logic [1:0]           byte_q;
   logic [2:0]           bit_q;
   logic [IDX_W-1:0]     data_q;
   logic [DATA_BITS-1:0] shift_q;
   logic [DATA_BITS-1:0] temp_q;
   logic                 ready_q;
   logic                 error_q;
   logic [1:0]           nx_byte;
   logic [2:0]           nx_bit;
   logic [7:0]           nx_cmd;
   logic                 last_data;

   assign last_data = (data_q == IDX_W'(DATA_BITS - 1));

   // position of the next command bit to transmit
   always_comb begin
      if (state_q == SQ_WRITE && slot_done_i) begin
         if (bit_q != 3'd7) begin
            nx_byte = byte_q;
            nx_bit  = bit_q + 3'd1;
         end else begin
            nx_byte = byte_q + 2'd1;
            nx_bit  = 3'd0;
         end
      end else begin
         nx_byte = byte_q;
         nx_bit  = 3'd0;
      end
      nx_cmd = cmd_byte(nx_byte);
   end

   always_comb begin
      slot_start_o = 1'b0;
      slot_kind_o  = SLOT_RESET;
      dly_start_o  = 1'b0;
      case (state_q)
         SQ_IDLE: begin
            slot_start_o = req_i;
         end
         SQ_RESET: begin
            if (slot_done_i && !slot_sample_i) begin
               slot_start_o = 1'b1;
               slot_kind_o  = nx_cmd[0] ? SLOT_WR1 : SLOT_WR0;
            end
         end
         SQ_WRITE: begin
            if (slot_done_i) begin
               if (bit_q == 3'd7 && byte_q == 2'd1) begin
                  dly_start_o = 1'b1;
               end else if (bit_q == 3'd7 && byte_q == 2'd3) begin
                  slot_start_o = 1'b1;
                  slot_kind_o  = SLOT_READ;
               end else begin
                  slot_start_o = 1'b1;
                  slot_kind_o  = nx_cmd[nx_bit] ? SLOT_WR1 : SLOT_WR0;
               end
            end
         end
         SQ_CONVERT: begin
            if (dly_done_i) begin
               slot_start_o = 1'b1;
               slot_kind_o  = nx_cmd[0] ? SLOT_WR1 : SLOT_WR0;
            end
         end
         SQ_READ: begin
            if (slot_done_i && !last_data) begin
               slot_start_o = 1'b1;
               slot_kind_o  = SLOT_READ;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         byte_q  <= '0;
         bit_q   <= '0;
         data_q  <= '0;
         shift_q <= '0;
         temp_q  <= '0;
         ready_q <= 1'b0;
         error_q <= 1'b0;
      end else begin
         ready_q <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (req_i) begin
                  state_q <= SQ_RESET;
                  error_q <= 1'b0;
               end
            end
            SQ_RESET: begin
               if (slot_done_i) begin
                  if (!slot_sample_i) begin
                     state_q <= SQ_WRITE;
                     byte_q  <= '0;
                     bit_q   <= '0;
                  end else begin
                     state_q <= SQ_IDLE;
                     error_q <= 1'b1;
                  end
               end
            end
            SQ_WRITE: begin
               if (slot_done_i) begin
                  byte_q <= nx_byte;
                  bit_q  <= nx_bit;
                  if (bit_q == 3'd7 && byte_q == 2'd1) begin
                     state_q <= SQ_CONVERT;
                  end else if (bit_q == 3'd7 && byte_q == 2'd3) begin
                     state_q <= SQ_READ;
                     data_q  <= '0;
                  end
               end
            end
            SQ_CONVERT: begin
               if (dly_done_i) begin
                  state_q <= SQ_WRITE;
               end
            end
            SQ_READ: begin
               if (slot_done_i) begin
                  shift_q <= {slot_sample_i, shift_q[DATA_BITS-1:1]};
                  if (last_data) begin
                     temp_q  <= {slot_sample_i, shift_q[DATA_BITS-1:1]};
                     ready_q <= 1'b1;
                     state_q <= SQ_IDLE;
                  end else begin
                     data_q <= data_q + 1'b1;
                  end
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign temp_o  = temp_q;
   assign ready_o = ready_q;
   assign error_o = error_q;

   // R8
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> !ready_o);

   // R6
   conv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_CONVERT) |-> !slot_done_i);

   // R6
   dly_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dly_done_i |-> (state_q == SQ_CONVERT));

   // R9
   busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SQ_IDLE && req_i && !slot_done_i && !dly_done_i) |-> !slot_start_o);

endmodule

// File: rtl/owtemp_reader.sv
module owtemp_reader
   import owtemp_pkg::*;
#(
   parameter int CLKS_PER_US    = 50,
   parameter int RESET_LOW_US   = 480,
   parameter int RESET_WIN_US   = 960,
   parameter int PRES_SAMPLE_US = 70,
   parameter int SLOT_US        = 65,
   parameter int RECOVERY_US    = 1,
   parameter int WR1_LOW_US     = 6,
   parameter int WR0_LOW_US     = 60,
   parameter int RD_LOW_US      = 6,
   parameter int RD_SAMPLE_US   = 15,
   parameter int CONV_WAIT_US   = 750000,
   parameter int DATA_BITS      = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic                 bus_in_i,
   output logic                 bus_drive_low_o,
   output logic [DATA_BITS-1:0] temp_o,
   output logic                 ready_o,
   output logic                 error_o
);

   logic       slot_start;
   slot_kind_e slot_kind;
   logic       slot_done;
   logic       slot_sample;
   logic       dly_start;
   logic       dly_done;

   owtemp_slot #(
      .CLKS_PER_US   (CLKS_PER_US),
      .RESET_LOW_US  (RESET_LOW_US),
      .RESET_WIN_US  (RESET_WIN_US),
      .PRES_SAMPLE_US(PRES_SAMPLE_US),
      .SLOT_US       (SLOT_US),
      .RECOVERY_US   (RECOVERY_US),
      .WR1_LOW_US    (WR1_LOW_US),
      .WR0_LOW_US    (WR0_LOW_US),
      .RD_LOW_US     (RD_LOW_US),
      .RD_SAMPLE_US  (RD_SAMPLE_US)
   ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (slot_start),
      .kind_i     (slot_kind),
      .line_i     (bus_in_i),
      .done_o     (slot_done),
      .drive_low_o(bus_drive_low_o),
      .sample_o   (slot_sample)
   );

   owtemp_usdelay #(
      .CLKS_PER_US(CLKS_PER_US),
      .DELAY_US   (CONV_WAIT_US)
   ) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(dly_start),
      .done_o (dly_done)
   );

   owtemp_seq #(
      .DATA_BITS(DATA_BITS)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req_i),
      .slot_done_i  (slot_done),
      .slot_sample_i(slot_sample),
      .dly_done_i   (dly_done),
      .slot_start_o (slot_start),
      .slot_kind_o  (slot_kind),
      .dly_start_o  (dly_start),
      .temp_o       (temp_o),
      .ready_o      (ready_o),
      .error_o      (error_o)
   );

   // R3
   error_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error_o) |-> !bus_drive_low_o);

   // R7
   ready_no_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> !error_o);

endmodule

// File: tb/owtemp_reader_bench.sv
`timescale 1ns/1ps
module owtemp_reader_bench;

   localparam int C    = 2;
   localparam int CONV = 100;
   localparam int NB   = 12;
   localparam int SLOT = 66 * C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          bus_in;
   logic          drive_low;
   logic [NB-1:0] temp;
   logic          ready;
   logic          error;

   logic          present = 1'b0;
   logic [NB-1:0] sens_val = '0;
   logic          dev_low = 1'b0;

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   int pulses_seen = 0;
   bit txn_done = 0;

   typedef struct {
      int w;
      int p;
      int wtag;
      int ptag;
   } pulse_t;

   pulse_t        exp_q[$];
   logic [NB-1:0] exp_t[$];

   initial forever #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   assign bus_in = !(drive_low || dev_low);

   owtemp_reader #(
      .CLKS_PER_US (C),
      .CONV_WAIT_US(CONV),
      .DATA_BITS   (NB)
   ) u_owtemp_reader (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_i          (req),
      .bus_in_i       (bus_in),
      .bus_drive_low_o(drive_low),
      .temp_o         (temp),
      .ready_o        (ready),
      .error_o        (error)
   );

   function automatic string tag_name(input int t);
      case (t)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   // sensor model: answers reset, pulls low during read slots for 0 bits
   initial begin
      automatic bit dpd = 0;
      automatic int drise = 0, nslot = 0, slot_no = 0;
      automatic int pres_lo = 0, pres_hi = 0, rd_hi = 0;
      forever begin
         @(negedge clk);
         if (drive_low && !dpd) begin
            drise   = cyc;
            slot_no = nslot;
            nslot++;
            if (slot_no >= 32 && slot_no < 32 + NB && !sens_val[slot_no-32])
               rd_hi = cyc + 30 * C;
         end
         if (!drive_low && dpd && (cyc - drise) >= 400 * C) begin
            pres_lo = cyc + 20 * C;
            pres_hi = cyc + 180 * C;
            nslot   = 0;
         end
         dpd = drive_low;
         dev_low = present && ((cyc >= pres_lo && cyc < pres_hi) || cyc < rd_hi);
      end
   end

   // monitor: pops expected pulses and results as the design produces them
   initial begin
      automatic bit pd = 0, rdy_next = 0;
      automatic int rise_c = 0, last_rise = 0, per = 0;
      automatic pulse_t e;
      automatic logic [NB-1:0] et;
      forever begin
         @(negedge clk);
         if (!rst_n) continue;
         if (drive_low && !pd) begin
            per       = cyc - last_rise;
            rise_c    = cyc;
            last_rise = cyc;
            pulses_seen++;
         end
         if (!drive_low && pd) begin
            if (exp_q.size() == 0) begin
               chk(0, "R9 unexpected pulse", cyc - rise_c, 0);
            end else begin
               e = exp_q.pop_front();
               chk((cyc - rise_c) == e.w, tag_name(e.wtag), cyc - rise_c, e.w);
               if (e.p >= 0) chk(per == e.p, tag_name(e.ptag), per, e.p);
            end
         end
         pd = drive_low;
         if (rdy_next) begin
            chk(!ready, "R8 strobe width", int'(ready), 0);
            rdy_next = 0;
         end else if (ready) begin
            if (exp_t.size() == 0) begin
               chk(0, "R8 unexpected ready", 1, 0);
            end else begin
               et = exp_t.pop_front();
               chk(temp == et, "R7", int'(temp), int'(et));
               chk((cyc - last_rise) == SLOT, "R8", cyc - last_rise, SLOT);
            end
            rdy_next = 1;
            txn_done = 1;
         end
      end
   end

   task automatic push_pulse(input int w, input int p, input int wt, input int pt);
      pulse_t it;
      it.w = w; it.p = p; it.wtag = wt; it.ptag = pt;
      exp_q.push_back(it);
   endtask

   task automatic fire_req();
      @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic run_txn(input logic [NB-1:0] val, input bit poke);
      logic [7:0] cb;
      int seen;
      push_pulse(480 * C, -1, 2, 2);
      for (int b = 0; b < 4; b++) begin
         cb = (b == 1) ? 8'h44 : (b == 3) ? 8'hBE : 8'hCC;
         for (int i = 0; i < 8; i++) begin
            if (b == 0 && i == 0)      push_pulse(cb[i] ? 6 * C : 60 * C, 960 * C, 4, 2);
            else if (b == 2 && i == 0) push_pulse(cb[i] ? 6 * C : 60 * C, SLOT + CONV * C, 4, 6);
            else                       push_pulse(cb[i] ? 6 * C : 60 * C, SLOT, 4, 5);
         end
      end
      for (int j = 0; j < NB; j++) push_pulse(6 * C, SLOT, 7, 5);
      exp_t.push_back(val);
      sens_val = val;
      present  = 1'b1;
      txn_done = 0;
      fire_req();
      chk(error == 1'b0, "R3 error cleared", int'(error), 0);
      if (poke) begin
         repeat (3000) @(negedge clk);
         fire_req();
         repeat (4000) @(negedge clk);
         fire_req();
      end
      while (!txn_done) @(negedge clk);
      chk(exp_q.size() == 0, "R4 all slots sent", exp_q.size(), 0);
      seen = pulses_seen;
      repeat (400) @(negedge clk);
      chk(pulses_seen == seen, "R9 idle after ready", pulses_seen, seen);
   endtask

   task automatic run_absent();
      int seen;
      present = 1'b0;
      push_pulse(480 * C, -1, 2, 2);
      seen = pulses_seen;
      fire_req();
      repeat (960 * C + 200) @(negedge clk);
      chk(error == 1'b1, "R3 error set", int'(error), 1);
      chk(pulses_seen == seen + 1, "R3 only reset pulse", pulses_seen - seen, 1);
      chk(exp_q.size() == 0, "R3 reset pulse seen", exp_q.size(), 0);
      chk(exp_t.size() == 0, "R3 no ready", exp_t.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(drive_low == 1'b0, "R1 drive", int'(drive_low), 0);
      chk(ready == 1'b0, "R1 ready", int'(ready), 0);
      chk(error == 1'b0, "R1 error", int'(error), 0);
      chk(temp == '0, "R1 temp", int'(temp), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(drive_low == 1'b0, "R1 idle drive", int'(drive_low), 0);
      chk(ready == 1'b0 && error == 1'b0, "R1 idle flags", int'({ready, error}), 0);

      run_txn(12'h5A3, 1'b0);
      run_txn(12'h801, 1'b1);
      run_absent();
      run_txn(12'h7FE, 1'b0);
      run_txn(12'hC35, 1'b0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule